// File: doc/BRIEF.md
# Sequential Floating-Point Significand Divider

This block divides the significand of one normalized floating-point operand by that of another. It resolves one quotient bit per clock. Each input significand is an unsigned fixed-point value in [1.0, 2.0). Its leading one sits in the top bit, and guard and round positions extend the low end. The caller also presents the two unbiased exponents. The block returns a quotient significand that is already normalized, the adjusted result exponent and a sticky bit for a later rounding stage.

A request is accepted when `start` is high while the block is idle. The operands are captured in that cycle. The first trial subtraction of divisor from dividend is made in the same cycle. Its sign decides whether the quotient would fall below 1.0. When it would, the dividend is pre-doubled and the exponent is lowered by one, so the leading quotient bit is always a one.

After capture, each clock shifts the partial remainder left and subtracts the divisor. The sign of that difference gives the next quotient bit, most significant first. After the last bit, `done` pulses for one cycle. The results then stay on the outputs until the next request. Operands are assumed finite and nonzero. Special values, rounding and packing belong to other stages.

Top module: `fp_sig_divider`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: When the dividend significand is greater than or equal to the divisor significand, `quo_exp` equals `dvd_exp - dvs_exp`.
- R3: When the dividend significand is smaller than the divisor significand, `quo_exp` equals `dvd_exp - dvs_exp - 1`. In every case, bit SIG_W-1 of `quo_sig` is 1 when `done` is high.
- R4: `quo_sig` equals floor(N / dvs_sig) truncated to SIG_W bits. N is the dividend significand, doubled when R3 applies, then shifted left by SIG_W-1.
- R5: `sticky` is 1 exactly when that division leaves a nonzero remainder.
- R6: `done` rises on the SIG_W-th rising clock edge after the edge that accepts `start`. `busy` stays high from the accepting edge until that edge.
- R7: `done` is high for exactly one cycle per accepted request.
- R8: A `start` pulse while `busy` is high is ignored. The running operation's results are unchanged, and no extra `done` is produced.
- R9: The exponent result does not wrap at the extremes of an 8-bit exponent field, for example -126 - 127 - 1 = -254 and 127 - (-126) = 253.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only while idle |
| dvd_sig | input | SIG_W | Dividend significand, leading one in bit SIG_W-1 |
| dvs_sig | input | SIG_W | Divisor significand, leading one in bit SIG_W-1 |
| dvd_exp | input | EXP_W | Dividend unbiased exponent, signed |
| dvs_exp | input | EXP_W | Divisor unbiased exponent, signed |
| busy | output | 1 | High while quotient bits are being produced |
| done | output | 1 | One-cycle pulse when results are ready |
| quo_sig | output | SIG_W | Normalized quotient significand |
| quo_exp | output | EXP_W | Signed result exponent |
| sticky | output | 1 | Nonzero-remainder indicator |

## Verification
The bench builds the divider with its default widths: a 26-bit significand (24 plus guard and round) and a 10-bit signed exponent. At these widths a 64-bit reference division gives the exact quotient and remainder of every operand pair. The full-length iteration, an exactly representable quotient (equal operands, divisor at 1.0) and a pre-doubled dividend can all be compared bit for bit. The same widths also let the exponent corners of an 8-bit field be driven without wrap.

// File: rtl/fp_sig_divider.sv
module fp_sig_divider #(
  parameter int SIG_W = 26,
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SIG_W-1:0]        dvd_sig,
  input  logic [SIG_W-1:0]        dvs_sig,
  input  logic signed [EXP_W-1:0] dvd_exp,
  input  logic signed [EXP_W-1:0] dvs_exp,
  output logic                    busy,
  output logic                    done,
  output logic [SIG_W-1:0]        quo_sig,
  output logic signed [EXP_W-1:0] quo_exp,
  output logic                    sticky
);
  localparam int CNT_W = $clog2(SIG_W + 1);

  logic [SIG_W-1:0] div_q;
  logic [SIG_W:0]   rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SIG_W+1:0] first_diff;
  logic [SIG_W+1:0] trial;
  logic [SIG_W:0]   kept;
  logic             below;
  logic             hit;

  assign first_diff = {2'b00, dvd_sig} - {2'b00, dvs_sig};
  assign below      = first_diff[SIG_W+1];
  assign trial      = {1'b0, rem_q} - {2'b00, div_q};
  assign hit        = ~trial[SIG_W+1];
  assign kept       = hit ? trial[SIG_W:0] : rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt_q   <= '0;
      div_q   <= '0;
      rem_q   <= '0;
      quo_sig <= '0;
      quo_exp <= '0;
      sticky  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        cnt_q   <= CNT_W'(SIG_W);
        div_q   <= dvs_sig;
        rem_q   <= below ? {dvd_sig, 1'b0} : {1'b0, dvd_sig};
        quo_exp <= dvd_exp - dvs_exp - {{(EXP_W-1){1'b0}}, below};
        quo_sig <= '0;
      end else if (busy) begin
        quo_sig <= {quo_sig[SIG_W-2:0], hit};
        rem_q   <= {kept[SIG_W-1:0], 1'b0};
        cnt_q   <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          sticky <= |kept;
        end
      end
    end
  end
endmodule

// File: rtl/fp_sig_divider_chk.sv
module fp_sig_divider_chk #(
  parameter int SIG_W = 26,
  parameter int EXP_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [SIG_W-1:0]        quo_sig,
  input logic signed [EXP_W-1:0] quo_exp
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R6
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy)); // R6
  AST_QUO_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n) done |-> quo_sig[SIG_W-1]); // R3
  AST_EXP_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy) && $past(start)) |-> $stable(quo_exp)); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || done)); // R8
endmodule

bind fp_sig_divider fp_sig_divider_chk #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quo_sig(quo_sig), .quo_exp(quo_exp)
);

// File: tb/fp_sig_divider_tb.sv
`timescale 1ns/1ps
module fp_sig_divider_tb;
  localparam int W = 26;
  localparam int E = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] dvd_sig = '0, dvs_sig = '0;
  logic signed [E-1:0] dvd_exp = '0, dvs_exp = '0;
  logic busy, done, sticky;
  logic [W-1:0] quo_sig;
  logic signed [E-1:0] quo_exp;

  always #2 clk = ~clk;

  fp_sig_divider #(.SIG_W(W), .EXP_W(E)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dvd_sig(dvd_sig), .dvs_sig(dvs_sig),
    .dvd_exp(dvd_exp), .dvs_exp(dvs_exp), .busy(busy), .done(done),
    .quo_sig(quo_sig), .quo_exp(quo_exp), .sticky(sticky)
  );

  typedef struct {
    logic [W-1:0]        q;
    logic signed [E-1:0] e;
    logic                s;
    int                  when;
    string               etag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit prev_done = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic op(input logic [W-1:0] x, input logic [W-1:0] y,
                    input int ex, input int ey, input string etag_hi, input string etag_lo);
    item_t it;
    logic [63:0] num;
    bit lt;
    while (busy) @(negedge clk);
    lt  = x < y;
    num = (lt ? {37'd0, x, 1'b0} : {38'd0, x}) << (W - 1);
    it.q = W'(num / {38'd0, y});
    it.s = (num % {38'd0, y}) != 0;
    it.e = E'(ex - ey - (lt ? 1 : 0));
    it.etag = lt ? etag_lo : etag_hi;
    it.when = cyc + 1 + W;
    sb.push_back(it);
    dvd_sig = x; dvs_sig = y; dvd_exp = E'(ex); dvs_exp = E'(ey);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic poke(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    dvd_sig = x; dvs_sig = y; dvd_exp = 10'sd99; dvs_exp = -10'sd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(!done, "R7 done width", longint'(done), 0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(quo_sig == it.q, "R4 quotient", longint'(quo_sig), longint'(it.q));
          chk(quo_exp == it.e, it.etag, longint'(quo_exp), longint'(it.e));
          chk(sticky == it.s, "R5 sticky", longint'(sticky), longint'(it.s));
          chk(cyc == it.when, "R6 latency", cyc, it.when);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
  end

  localparam logic [W-1:0] ONE  = W'(1) << (W - 1);
  localparam logic [W-1:0] MAXS = '1;
  localparam logic [W-1:0] ONEH = W'(3) << (W - 2);

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset state", longint'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", longint'({busy, done}), 0);

    op(ONE, ONE, 3, 1, "R2 exponent", "R3 exponent");
    op(MAXS, ONE, 0, 0, "R2 exponent", "R3 exponent");
    op(ONE, MAXS, 5, 7, "R2 exponent", "R3 exponent");
    op(ONEH, ONE, -4, 2, "R2 exponent", "R3 exponent");
    op(ONE, ONEH, 10, -3, "R2 exponent", "R3 exponent");
    op(ONE + W'(1), MAXS, -126, 127, "R9 exponent", "R9 exponent");
    op(MAXS, ONEH, 127, -126, "R9 exponent", "R9 exponent");

    op(ONEH, ONE + W'(7), 1, 1, "R2 exponent", "R3 exponent");
    poke(ONE, MAXS);
    poke(MAXS, ONE);

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = ONE | W'($urandom());
      b = ONE | W'($urandom());
      op(a, b, int'($urandom_range(0, 200)) - 100, int'($urandom_range(0, 200)) - 100,
         "R2 exponent", "R3 exponent");
    end

    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R8 pending results", sb.size(), 0);
    summary();
  end
endmodule